// File: doc/BRIEF.md
# Sixteen-Bit Peripheral Timer with Compare Clear

A 16-bit up-counter for a microcontroller-style peripheral bus. Software reaches it through byte-wide reads and writes at four addresses: count low byte, count high byte, control, and interrupt. The counter runs on the system clock or on an external clock input. In the external case the input is edge-detected, either through a synchronizer or through a single sampling flop. A 2-bit prescaler sits in front of the counter. When the count wraps past its top it sets a sticky interrupt flag, and a separate enable bit gates that flag onto the interrupt line.

An external compare unit can pulse a trigger input that clears the count. This makes the compare value the timer period. The clear never sets the interrupt flag, and a software write to the count in the same cycle overrides it. With the 16-bit access mode bit set, the high byte is staged through a buffer so that software reads and writes the full count as one coherent value.

Address map: 0 is the low count byte, 1 the high count byte, 2 the control byte, and 3 the interrupt byte. `rdata` always shows the addressed register.

Top module: `tmr16_evt`

## Requirements
- R1: While running, each count tick adds one to the 16-bit count, and the count wraps from 0xFFFF to 0x0000.
- R2: A wrap sets the interrupt flag (bit 0 at address 3). The flag stays set until software writes address 3 with bit 0 = 0. A wrap in the same cycle as that write leaves the flag set.
- R3: `irq` is high exactly when the flag and the enable bit (bit 1 at address 3) are both set. A clear enable does not stop the flag from being set.
- R4: In internal-clock mode and in synchronized external mode, a high `evt_trig` clears the count to 0x0000 on the next edge, whether or not the timer runs.
- R5: A clear caused by `evt_trig` never sets the interrupt flag, even when the count was 0xFFFF.
- R6: When a count-byte write and `evt_trig` fall in the same cycle, the write takes effect and the trigger is ignored.
- R7: In unsynchronized external mode (control bit 1 = 1 and bit 2 = 1), `evt_trig` leaves the count unchanged.
- R8: The control byte has bit 0 = run, bit 1 = external clock source, bit 2 = synchronizer bypass, bits 4:3 = prescaler code, and bit 7 = 16-bit access mode. Bits 6:5 read as 0. Reset clears the control byte, the count and the interrupt byte.
- R9: Prescaler codes 0, 1, 2 and 3 give one count tick per 1, 2, 4 and 8 source events. Any write to the count restarts the prescaler.
- R10: In synchronized external mode, each rising edge of `ext_clk` gives one source event after a two-flop synchronizer.
- R11: In 16-bit access mode, reading address 0 copies the high count byte into a buffer, and address 1 then reads that buffer. Writing address 1 fills the buffer only, and writing address 0 loads the count as {buffer, data}. With the mode clear, both count bytes are read and written directly.
- R12: With run clear, the count holds its value, but byte writes to it still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the 16-bit read latch) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| ext_clk | input | 1 | External count clock |
| evt_trig | input | 1 | Clear trigger from the compare unit |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a single bus operation per cycle: `wr_en` and `rd_en` are never high together, and each operation addresses one register. They also assume `ext_clk` stays at each level for several system clocks. The bench issues every access through one task per cycle, and it holds `ext_clk` high and low for six cycles each. The random phase draws the start count, the prescaler code and the run length. Directed cases cover the wrap, the trigger corners and the buffered 16-bit access.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam logic [1:0] ADR_LO  = 2'd0;
    localparam logic [1:0] ADR_HI  = 2'd1;
    localparam logic [1:0] ADR_CTL = 2'd2;
    localparam logic [1:0] ADR_IRQ = 2'd3;

    typedef struct packed {
        logic       rw16;
        logic [1:0] ps;
        logic       nosync;
        logic       ext;
        logic       run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.rw16   = b[7];
        c.ps     = b[4:3];
        c.nosync = b[2];
        c.ext    = b[1];
        c.run    = b[0];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        return {c.rw16, 2'b00, c.ps, c.nosync, c.ext, c.run};
    endfunction
endpackage

// File: rtl/tmr16_tick.sv
module tmr16_tick #(
    parameter int PS_W   = 2,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_in,
    input  logic            run,
    input  logic            ext_sel,
    input  logic            nosync,
    input  logic [PS_W-1:0] ps,
    input  logic            pre_clr,
    output logic            tick_o
);
    localparam int PC_W = (1 << PS_W) - 1;
    localparam int CH_W = SYNC_N + 1;

    typedef struct packed {
        logic [CH_W-1:0] ch;
        logic [PC_W-1:0] pc;
    } st_t;

    st_t s_q, s_d;
    logic fast_edge, sync_edge, src_ok, roll;
    logic [PC_W-1:0] mask;

    always_comb begin
        fast_edge = s_q.ch[0] & ~s_q.ch[1];
        sync_edge = s_q.ch[SYNC_N-1] & ~s_q.ch[SYNC_N];
        src_ok    = ext_sel ? (nosync ? fast_edge : sync_edge) : 1'b1;
        for (int i = 0; i < PC_W; i++) begin
            mask[i] = (i < int'(ps));
        end
        roll = run && src_ok && ((s_q.pc & mask) == mask);

        s_d.ch = {s_q.ch[CH_W-2:0], ext_in};
        if (pre_clr) begin
            s_d.pc = '0;
        end else if (run && src_ok) begin
            s_d.pc = roll ? '0 : s_q.pc + PC_W'(1);
        end else begin
            s_d.pc = s_q.pc;
        end
        tick_o = roll;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: a count write restarts the prescaler
    a_r9_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        pre_clr |=> (s_q.pc == '0));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
    parameter int CNT_W = 16,
    localparam int HI_W = CNT_W - 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             rw16,
    input  logic             rd_lo,
    input  logic             trig_en,
    input  logic             irq_wr,
    input  logic [1:0]       irq_wdata,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [HI_W-1:0]  buf_o,
    output logic             flag_o,
    output logic             ie_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [HI_W-1:0]  hbuf;
        logic             flag;
        logic             ie;
    } st_t;

    st_t s_q, s_d;
    logic cnt_wr, wrap;

    always_comb begin
        s_d    = s_q;
        cnt_wr = wr_lo || (wr_hi && !rw16);
        wrap   = 1'b0;

        if (wr_hi) begin
            if (rw16) s_d.hbuf = wdata[HI_W-1:0];
            else      s_d.cnt[CNT_W-1:8] = wdata[HI_W-1:0];
        end
        if (wr_lo) begin
            s_d.cnt[7:0] = wdata;
            if (rw16) s_d.cnt[CNT_W-1:8] = s_q.hbuf;
        end
        if (!cnt_wr) begin
            if (trig_en) begin
                s_d.cnt = '0;
            end else if (tick) begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
                wrap    = (s_q.cnt == CNT_MAX);
            end
        end
        if (rd_lo && rw16) s_d.hbuf = s_q.cnt[CNT_W-1:8];

        if (irq_wr) begin
            s_d.flag = irq_wdata[0];
            s_d.ie   = irq_wdata[1];
        end
        if (wrap) s_d.flag = 1'b1;

        cnt_o  = s_q.cnt;
        buf_o  = s_q.hbuf;
        flag_o = s_q.flag;
        ie_o   = s_q.ie;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: wrap from top to zero, and the flag follows
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.cnt == CNT_MAX && !wr_lo && !wr_hi && !trig_en)
        |=> (s_q.cnt == '0 && s_q.flag));
    // R2: flag is sticky until software writes it
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !irq_wr) |=> s_q.flag);
    // R4: qualified trigger clears the count
    a_r4_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && !wr_lo && !(wr_hi && !rw16)) |=> (s_q.cnt == '0));
    // R5: trigger clear does not raise the flag
    a_r5_trig_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && !s_q.flag && !irq_wr) |=> !s_q.flag);
endmodule

// File: rtl/tmr16_evt.sv
module tmr16_evt #(
    parameter int PS_W   = 2,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ext_clk,
    input  logic       evt_trig,
    output logic       irq
);
    import tmr16_pkg::*;

    localparam int CNT_W = 16;

    ctrl_t ctrl_q, ctrl_d;
    logic wr_lo, wr_hi, wr_ctl, wr_irq, rd_lo, cnt_wr, trig_en, tick;
    logic [CNT_W-1:0] cnt;
    logic [7:0] hbuf;
    logic flag, ie;
    logic unused_bits;

    always_comb begin
        wr_lo   = wr_en && (addr == ADR_LO);
        wr_hi   = wr_en && (addr == ADR_HI);
        wr_ctl  = wr_en && (addr == ADR_CTL);
        wr_irq  = wr_en && (addr == ADR_IRQ);
        rd_lo   = rd_en && (addr == ADR_LO);
        cnt_wr  = wr_lo || (wr_hi && !ctrl_q.rw16);
        trig_en = evt_trig && !cnt_wr && !(ctrl_q.ext && ctrl_q.nosync);
        ctrl_d  = wr_ctl ? ctrl_from_byte(wdata) : ctrl_q;
        unused_bits = ^wdata[6:5];

        unique case (addr)
            ADR_LO:  rdata = cnt[7:0];
            ADR_HI:  rdata = ctrl_q.rw16 ? hbuf : cnt[15:8];
            ADR_CTL: rdata = ctrl_to_byte(ctrl_q);
            default: rdata = {6'b0, ie, flag};
        endcase
        irq = flag && ie;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    tmr16_tick #(.PS_W(PS_W), .SYNC_N(SYNC_N)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_in  (ext_clk),
        .run     (ctrl_q.run),
        .ext_sel (ctrl_q.ext),
        .nosync  (ctrl_q.nosync),
        .ps      (PS_W'(ctrl_q.ps)),
        .pre_clr (cnt_wr),
        .tick_o  (tick)
    );

    tmr16_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rw16      (ctrl_q.rw16),
        .rd_lo     (rd_lo),
        .trig_en   (trig_en),
        .irq_wr    (wr_irq),
        .irq_wdata (wdata[1:0]),
        .wdata     (wdata),
        .cnt_o     (cnt),
        .buf_o     (hbuf),
        .flag_o    (flag),
        .ie_o      (ie)
    );

    // R6: a low-byte write beats a coincident trigger
    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !ctrl_q.rw16 && evt_trig) |=> (cnt[7:0] == $past(wdata)));
    // R7: unsynchronized external mode ignores the trigger
    a_r7_unsync_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ext && ctrl_q.nosync && !ctrl_q.run && evt_trig && !wr_lo && !wr_hi)
        |=> $stable(cnt));
    // R12: stopped timer holds its count
    a_r12_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_lo && !wr_hi && !evt_trig) |=> $stable(cnt));
    // R3: irq only with enable
    a_r3_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie) |-> !irq);
endmodule

// File: tb/sim_tmr16_evt.sv
module sim_tmr16_evt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ext_clk = 1'b0;
    logic       evt_trig = 1'b0;
    logic       irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr16_evt u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .evt_trig(evt_trig), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic trig_pulse();
        evt_trig = 1'b1;
        @(negedge clk);
        evt_trig = 1'b0;
    endtask

    task automatic ext_pulse();
        ext_clk = 1'b1; idle(6);
        ext_clk = 1'b0; idle(6);
    endtask

    // read count in whatever mode is current (16-bit mode: low then buffered high)
    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        bus_rd(2'd0, lo);
        bus_rd(2'd1, hi);
        v = {hi, lo};
    endtask

    function automatic int expect_count(input int start, input int runs, input int ps);
        return (start + (runs >> ps)) & 16'hFFFF;
    endfunction

    function automatic int expect_flag(input int start, input int runs, input int ps);
        return ((start + (runs >> ps)) > 16'hFFFF) ? 1 : 0;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] d;
        int v;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        bus_rd(2'd2, d); check("R8 ctrl reset", d, 0);
        rd_cnt(v);       check("R8 count reset", v, 0);
        bus_rd(2'd3, d); check("R8 irq reg reset", d, 0);
        check("R3 irq low at reset", irq, 0);

        // R8 control layout, reserved bits read zero
        bus_wr(2'd2, 8'hFF); bus_rd(2'd2, d); check("R8 ctrl readback", d, 8'h9F);
        bus_wr(2'd2, 8'h00);

        // R12 writes accepted while stopped, count holds
        bus_wr(2'd0, 8'h34); bus_wr(2'd1, 8'h12);
        idle(10);
        rd_cnt(v); check("R12 hold while off", v, 16'h1234);

        // R4 trigger clears in internal mode; R5 no flag
        trig_pulse();
        rd_cnt(v); check("R4 trigger clear", v, 0);
        bus_wr(2'd0, 8'hFF); bus_wr(2'd1, 8'hFF);
        trig_pulse();
        rd_cnt(v); check("R4 clear from top", v, 0);
        bus_rd(2'd3, d); check("R5 no flag on trigger clear", d & 1, 0);

        // R6 write beats coincident trigger
        bus_wr(2'd0, 8'h78); bus_wr(2'd1, 8'h56);
        evt_trig = 1'b1; bus_wr(2'd0, 8'h9A); evt_trig = 1'b0;
        rd_cnt(v); check("R6 write wins", v, 16'h569A);

        // R7 unsynchronized external ignores trigger
        bus_wr(2'd2, 8'h06);
        bus_wr(2'd0, 8'h02); bus_wr(2'd1, 8'h01);
        trig_pulse();
        rd_cnt(v); check("R7 trigger ignored", v, 16'h0102);
        // R4 synchronized external honours trigger
        bus_wr(2'd2, 8'h02);
        trig_pulse();
        rd_cnt(v); check("R4 sync counter clear", v, 0);

        // R10 synchronized external counting
        bus_wr(2'd2, 8'h03);
        for (int i = 0; i < 5; i++) ext_pulse();
        bus_wr(2'd2, 8'h02);
        rd_cnt(v); check("R10 ext edges counted", v, 5);
        // R9 prescale by 2 on external edges, restarted by count write
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd2, 8'h0B);
        for (int i = 0; i < 6; i++) ext_pulse();
        bus_wr(2'd2, 8'h00);
        rd_cnt(v); check("R9 ext prescale 2", v, 3);

        // R1/R2/R3 wrap, sticky flag, enable gating
        bus_wr(2'd0, 8'hFF); bus_wr(2'd1, 8'hFF);
        bus_wr(2'd2, 8'h01); bus_wr(2'd2, 8'h00);
        rd_cnt(v); check("R1 wrap to zero", v, 0);
        idle(5);
        bus_rd(2'd3, d); check("R2 flag sticky", d, 8'h01);
        check("R3 irq gated off", irq, 0);
        bus_wr(2'd3, 8'h03); #1 check("R3 irq with enable", irq, 1);
        bus_wr(2'd3, 8'h02); #1 check("R2 flag cleared", irq, 0);
        bus_rd(2'd3, d); check("R2 irq reg after clear", d, 8'h02);
        bus_wr(2'd3, 8'h00);

        // R11 buffered 16-bit access
        bus_wr(2'd2, 8'h80);
        bus_wr(2'd1, 8'hAB); bus_wr(2'd0, 8'hCD);
        bus_rd(2'd0, d); check("R11 low byte", d, 8'hCD);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, 8'h11);
        bus_wr(2'd2, 8'h80);
        bus_rd(2'd1, d); check("R11 buffered high", d, 8'hAB);
        bus_wr(2'd1, 8'h77);
        bus_wr(2'd2, 8'h00);
        bus_rd(2'd1, d); check("R11 live high untouched", d, 8'h11);

        // R1/R9/R2 random runs in 16-bit mode
        for (int it = 0; it < 40; it++) begin
            int start, ps, m;
            logic [7:0] lo8;
            start = (it % 4 == 0) ? (16'hFFF0 + int'($urandom % 16)) : int'($urandom % 65536);
            ps = int'($urandom % 4);
            m  = int'($urandom % 40);
            bus_wr(2'd2, 8'h80);
            bus_wr(2'd3, 8'h00);
            bus_wr(2'd1, 8'(start >> 8));
            bus_wr(2'd0, 8'(start));
            bus_wr(2'd2, 8'h81 | 8'(ps << 3));
            idle(m);
            bus_wr(2'd2, 8'h80 | 8'(ps << 3));
            rd_cnt(v);
            check("R1 R9 random count", v, expect_count(start, m + 1, ps));
            bus_rd(2'd3, lo8);
            check("R2 random flag", lo8 & 1, expect_flag(start, m + 1, ps));
        end

        done = 1'b1;
        report();
    end
endmodule